// File: doc/BRIEF.md
# Programmed-I/O Single-Frame Network Buffer

This block sits between a host register bus and a pair of byte streams. It holds one received frame and one frame to be sent, and the host moves every byte by hand. An incoming byte stream fills the receive store. The host then pulls the bytes out one at a time through a data register, and a count register tracks how many remain. To send a frame, the host writes a length and then writes that many bytes to a data register. The block then plays the frame out on an outgoing byte stream.

Three sticky flags are kept: transmit finished, receive finished, and a self-test marker. They drive a level interrupt. A busy bit gates reception, so a new frame can only land after the host has cleared every flag. Flags are cleared by a write that is decoded in priority order. Writing only the self-test bit returns the whole block to its reset state and leaves the marker set. Reading the flag register then clears the marker.

Top module: `frame_pio_nic`

## Requirements
- R1: After reset, busy reads 1, the receive count, transmit count and flag register read 0, the interrupt is low and the receive stream is not ready.
- R2: Only address bits 5:0 are decoded. Offset 0x00 and 0x04 return the two identification words. Offset 0x08 returns busy in bit 0, 0x0C the receive count, 0x10 the transmit count and 0x14 the flags (bit 0 transmit done, bit 1 receive done, bit 31 self-test). Offset 0x1C returns receive data in bits 7:0. Offsets 0x18, 0x20 and every other offset read 0.
- R3: A receive byte is taken only while busy is 0 and the receive count is below MAX_LEN. Otherwise rx_ready is low and the stream stalls.
- R4: A frame shorter than MAX_LEN that ends with rx_last loads the receive count with its length, restarts the read position at its first byte, sets receive done and sets busy.
- R5: A frame of MAX_LEN bytes or more is dropped. The receive count, the flags and busy keep their values.
- R6: A read at 0x1C with a nonzero count returns the next byte in arrival order and lowers the count by one. With the count at 0 it returns 0 and changes nothing.
- R7: A write at 0x10 loads the transmit count if the value is at most MAX_LEN and loads 0 otherwise. In both cases the bytes written so far are discarded.
- R8: Each write at 0x20 stores bits 7:0. When the number of bytes written equals the transmit count or reaches MAX_LEN, the frame goes out on the tx stream in write order, with tx_last on its final byte. The transmit count returns to 0, transmit done is set and busy is set.
- R9: Writes at 0x20 have no effect while a frame is still on the tx stream.
- R10: A write at 0x14 with bit 0 set clears transmit done. Otherwise, bit 1 set clears receive done. Otherwise, bit 31 set resets the whole block and then sets the self-test flag. A zero write changes no flag. After the write, busy equals the OR of the flags.
- R11: A read at 0x14 returns the flags and then clears the self-test flag. irq is high exactly while any flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Register access this cycle |
| bus_we | input | 1 | 1 write, 0 read |
| bus_addr | input | 32 | Byte address, low 6 bits decoded |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| irq | output | 1 | Level interrupt |
| rx_valid | input | 1 | Incoming byte present |
| rx_data | input | 8 | Incoming byte |
| rx_last | input | 1 | Final byte of the incoming frame |
| rx_ready | output | 1 | Block takes the incoming byte |
| tx_valid | output | 1 | Outgoing byte present |
| tx_data | output | 8 | Outgoing byte |
| tx_last | output | 1 | Final byte of the outgoing frame |
| tx_ready | input | 1 | Sink takes the outgoing byte |

## Verification
The bench builds the block with MAX_LEN set to 16. With that value, the length limits can be hit with short stimulus: a 15-byte frame that is accepted, a 16-byte frame that is dropped, a transmit that completes on the limit with no count written, and an oversized count write. Both identification words are overridden, so the bench can tell each of them apart from a default.

// File: rtl/frame_pio_nic.sv
module frame_pio_nic #(
  parameter int          MAX_LEN  = 1514,
  parameter logic [31:0] ID_WORD0 = 32'h4349_4E46,
  parameter logic [31:0] ID_WORD1 = 32'h3050_4950
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_we,
  input  logic [31:0] bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq,
  input  logic        rx_valid,
  input  logic [7:0]  rx_data,
  input  logic        rx_last,
  output logic        rx_ready,
  output logic        tx_valid,
  output logic [7:0]  tx_data,
  output logic        tx_last,
  input  logic        tx_ready
);
  localparam int CW = $clog2(MAX_LEN + 1);
  localparam logic [CW-1:0] LIM      = CW'(MAX_LEN);
  localparam logic [CW-1:0] LAST_IDX = CW'(MAX_LEN - 1);
  localparam logic [CW-1:0] ONE      = CW'(1);
  localparam logic [5:0] A_ID0 = 6'h00, A_ID1 = 6'h04, A_BUSY = 6'h08, A_RXCNT = 6'h0C,
                         A_TXCNT = 6'h10, A_FLAGS = 6'h14, A_RXDAT = 6'h1C, A_TXDAT = 6'h20;

  logic busy, f_tx, f_rx, f_test, sending;
  logic [CW-1:0] rx_cnt, rx_rd, rx_wp, tx_cnt, tx_wp, tx_len, tx_rd;
  logic busy_n, f_tx_n, f_rx_n, f_test_n, sending_n;
  logic [CW-1:0] rx_cnt_n, rx_rd_n, rx_wp_n, tx_cnt_n, tx_wp_n, tx_len_n, tx_rd_n;
  logic [7:0] rx_mem [MAX_LEN];
  logic [7:0] tx_mem [MAX_LEN];

  logic [5:0] a;
  logic rd, wr, rx_fire, rx_commit, tx_push, tx_done, tx_pop, flag_wr;

  assign a         = bus_addr[5:0];
  assign rd        = bus_sel & ~bus_we;
  assign wr        = bus_sel & bus_we;
  assign flag_wr   = wr & (a == A_FLAGS);
  assign rx_ready  = ~busy & (rx_cnt < LIM);
  assign rx_fire   = rx_valid & rx_ready;
  assign rx_commit = rx_fire & rx_last & (rx_wp != LAST_IDX);
  assign tx_push   = wr & (a == A_TXDAT) & ~sending;
  assign tx_done   = tx_push & ((tx_wp + ONE == tx_cnt) | (tx_wp + ONE == LIM));
  assign tx_valid  = sending;
  assign tx_data   = tx_mem[tx_rd];
  assign tx_last   = sending & (tx_rd == tx_len - ONE);
  assign tx_pop    = sending & tx_ready;
  assign irq       = f_tx | f_rx | f_test;

  always_ff @(posedge clk) begin
    if (rx_fire && rx_wp != LAST_IDX) rx_mem[rx_wp] <= rx_data;
    if (tx_push) tx_mem[tx_wp] <= bus_wdata[7:0];
  end

  always_comb begin
    bus_rdata = '0;
    if (rd) begin
      case (a)
        A_ID0:   bus_rdata = ID_WORD0;
        A_ID1:   bus_rdata = ID_WORD1;
        A_BUSY:  bus_rdata = {31'b0, busy};
        A_RXCNT: bus_rdata = 32'(rx_cnt);
        A_TXCNT: bus_rdata = 32'(tx_cnt);
        A_FLAGS: bus_rdata = {f_test, 29'b0, f_rx, f_tx};
        A_RXDAT: if (rx_cnt != '0) bus_rdata = {24'b0, rx_mem[rx_rd]};
        default: bus_rdata = '0;
      endcase
    end
  end

  always_comb begin
    busy_n = busy; f_tx_n = f_tx; f_rx_n = f_rx; f_test_n = f_test; sending_n = sending;
    rx_cnt_n = rx_cnt; rx_rd_n = rx_rd; rx_wp_n = rx_wp;
    tx_cnt_n = tx_cnt; tx_wp_n = tx_wp; tx_len_n = tx_len; tx_rd_n = tx_rd;

    if (rd && a == A_RXDAT && rx_cnt != '0) begin
      rx_cnt_n = rx_cnt - ONE;
      rx_rd_n  = rx_rd + ONE;
    end
    if (rd && a == A_FLAGS) f_test_n = 1'b0;

    if (tx_pop) begin
      if (tx_last) begin sending_n = 1'b0; tx_rd_n = '0; end
      else tx_rd_n = tx_rd + ONE;
    end
    if (wr && a == A_TXCNT) begin
      tx_cnt_n = (bus_wdata <= 32'(MAX_LEN)) ? bus_wdata[CW-1:0] : '0;
      tx_wp_n  = '0;
    end
    if (tx_push) begin
      if (tx_done) begin
        sending_n = 1'b1; tx_len_n = tx_wp + ONE; tx_rd_n = '0;
        tx_cnt_n = '0; tx_wp_n = '0; f_tx_n = 1'b1; busy_n = 1'b1;
      end else tx_wp_n = tx_wp + ONE;
    end

    if (rx_fire) begin
      if (rx_last) rx_wp_n = '0;
      else if (rx_wp != LAST_IDX) rx_wp_n = rx_wp + ONE;
    end
    if (rx_commit) begin
      busy_n = 1'b1; rx_cnt_n = rx_wp + ONE; rx_rd_n = '0; f_rx_n = 1'b1;
    end

    if (flag_wr) begin
      if (bus_wdata[0]) f_tx_n = 1'b0;
      else if (bus_wdata[1]) f_rx_n = 1'b0;
      else if (bus_wdata[31]) begin
        f_tx_n = 1'b0; f_rx_n = 1'b0; f_test_n = 1'b1; sending_n = 1'b0;
        rx_cnt_n = '0; rx_rd_n = '0; rx_wp_n = '0;
        tx_cnt_n = '0; tx_wp_n = '0; tx_len_n = '0; tx_rd_n = '0;
      end
      busy_n = f_tx_n | f_rx_n | f_test_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b1; f_tx <= 1'b0; f_rx <= 1'b0; f_test <= 1'b0; sending <= 1'b0;
      rx_cnt <= '0; rx_rd <= '0; rx_wp <= '0;
      tx_cnt <= '0; tx_wp <= '0; tx_len <= '0; tx_rd <= '0;
    end else begin
      busy <= busy_n; f_tx <= f_tx_n; f_rx <= f_rx_n; f_test <= f_test_n; sending <= sending_n;
      rx_cnt <= rx_cnt_n; rx_rd <= rx_rd_n; rx_wp <= rx_wp_n;
      tx_cnt <= tx_cnt_n; tx_wp <= tx_wp_n; tx_len <= tx_len_n; tx_rd <= tx_rd_n;
    end
  end

  // R4
  rx_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_commit && !flag_wr) |=> (busy && f_rx && rx_rd == '0 && rx_cnt != '0));

  // R5
  rx_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_fire && rx_last && rx_wp == LAST_IDX && !bus_sel && !tx_pop) |=>
      ($stable(rx_cnt) && $stable(f_rx) && $stable(busy)));

  // R6
  rx_read_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && a == A_RXDAT && rx_cnt != '0 && !rx_fire) |=> (rx_cnt == $past(rx_cnt) - ONE));

  // R7
  tx_count_clip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && a == A_TXCNT && bus_wdata > 32'(MAX_LEN)) |=> (tx_cnt == '0));

  // R8
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready && !flag_wr) |=> (tx_valid && $stable(tx_data) && $stable(tx_last)));

  // R10
  self_test_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_wr && bus_wdata[1:0] == 2'b00 && bus_wdata[31]) |=>
      (f_test && !f_tx && !f_rx && busy && !tx_valid && rx_cnt == '0));
endmodule

// File: tb/frame_pio_nic_test.sv
`timescale 1ns/1ps
module frame_pio_nic_test;
  localparam int ML = 16;
  localparam logic [31:0] ID0 = 32'h1357_9BDF;
  localparam logic [31:0] ID1 = 32'h2468_ACE0;

  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_sel = 0, bus_we = 0;
  logic [31:0] bus_addr = 0, bus_wdata = 0, bus_rdata;
  logic irq, rx_valid = 0, rx_last = 0, rx_ready, tx_valid, tx_last, tx_ready = 0;
  logic [7:0] rx_data = 0, tx_data;

  int checks = 0, fails = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  frame_pio_nic #(.MAX_LEN(ML), .ID_WORD0(ID0), .ID_WORD1(ID1)) uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq), .rx_valid(rx_valid),
    .rx_data(rx_data), .rx_last(rx_last), .rx_ready(rx_ready), .tx_valid(tx_valid),
    .tx_data(tx_data), .tx_last(tx_last), .tx_ready(tx_ready));

  // reference model
  int m_busy, m_rxc, m_rxr, m_txc, m_ftx, m_frx, m_ft;
  logic [7:0] m_rb[$], m_txq[$], m_out[$], m_inq[$], got[$];

  task automatic model_reset();
    m_busy = 1; m_rxc = 0; m_rxr = 0; m_txc = 0; m_ftx = 0; m_frx = 0; m_ft = 0;
    m_txq.delete(); m_out.delete(); m_inq.delete();
  endtask

  function automatic logic [31:0] model_rd(input logic [5:0] a);
    case (a)
      6'h00: return ID0;
      6'h04: return ID1;
      6'h08: return 32'(m_busy);
      6'h0C: return 32'(m_rxc);
      6'h10: return 32'(m_txc);
      6'h14: return {m_ft[0], 29'b0, m_frx[0], m_ftx[0]};
      6'h1C: return (m_rxc > 0) ? {24'b0, m_rb[m_rxr]} : 32'b0;
      default: return 32'b0;
    endcase
  endfunction

  always @(posedge clk) begin
    logic [5:0] a;
    bit rdv, wrv, rdy0, snd0;
    if (!rst_n) model_reset();
    else begin
      a = bus_addr[5:0];
      rdv = bus_sel && !bus_we;
      wrv = bus_sel && bus_we;
      rdy0 = (m_busy == 0) && (m_rxc < ML);
      snd0 = m_out.size() > 0;
      if (rdv && a == 6'h1C && m_rxc > 0) begin m_rxc--; m_rxr++; end
      if (rdv && a == 6'h14) m_ft = 0;
      if (snd0 && tx_ready) void'(m_out.pop_front());
      if (wrv && a == 6'h10) begin
        m_txc = (bus_wdata <= ML) ? int'(bus_wdata) : 0;
        m_txq.delete();
      end
      if (wrv && a == 6'h20 && !snd0) begin
        m_txq.push_back(bus_wdata[7:0]);
        if (m_txq.size() == m_txc || m_txq.size() == ML) begin
          m_out = m_txq; m_txq.delete(); m_txc = 0; m_ftx = 1; m_busy = 1;
        end
      end
      if (rx_valid && rdy0) begin
        if (m_inq.size() < ML) m_inq.push_back(rx_data);
        if (rx_last) begin
          if (m_inq.size() < ML) begin
            m_rb = m_inq; m_rxc = m_inq.size(); m_rxr = 0; m_frx = 1; m_busy = 1;
          end
          m_inq.delete();
        end
      end
      if (wrv && a == 6'h14) begin
        if (bus_wdata[0]) m_ftx = 0;
        else if (bus_wdata[1]) m_frx = 0;
        else if (bus_wdata[31]) begin model_reset(); m_ft = 1; end
        m_busy = (m_ftx | m_frx | m_ft) != 0;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n && !done) begin
    chk("R11 irq level", irq, (m_ftx | m_frx | m_ft) != 0);
    chk("R3 rx_ready", rx_ready, (m_busy == 0) && (m_rxc < ML));
    chk("R8 tx_valid", tx_valid, m_out.size() > 0);
    if (m_out.size() > 0) begin
      chk("R8 tx_data", tx_data, m_out[0]);
      chk("R8 tx_last", tx_last, m_out.size() == 1);
    end
    if (bus_sel && !bus_we) chk("R2 bus_rdata", bus_rdata, model_rd(bus_addr[5:0]));
    if (tx_valid && tx_ready) got.push_back(tx_data);
  end

  task automatic bus_wr(input logic [31:0] ad, input logic [31:0] d);
    @(posedge clk); #1 bus_sel = 1; bus_we = 1; bus_addr = ad; bus_wdata = d;
    @(posedge clk); #1 bus_sel = 0; bus_we = 0;
  endtask

  task automatic bus_rd(input logic [31:0] ad, input logic [31:0] exp, input string tag);
    @(posedge clk); #1 bus_sel = 1; bus_we = 0; bus_addr = ad;
    @(negedge clk); chk(tag, bus_rdata, exp);
    @(posedge clk); #1 bus_sel = 0;
  endtask

  task automatic send_rx(input int n, input logic [7:0] base);
    bit r;
    for (int i = 0; i < n; i++) begin
      @(posedge clk); #1 rx_valid = 1; rx_data = base + 8'(i); rx_last = (i == n - 1);
      forever begin
        @(negedge clk); r = rx_ready;
        @(posedge clk);
        if (r) break;
      end
      #1 rx_valid = 0; rx_last = 0;
    end
  endtask

  task automatic drain();
    @(negedge clk);
    while (tx_valid) @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    @(negedge clk);
    chk("R1 irq", irq, 0); chk("R1 rx_ready", rx_ready, 0); chk("R1 tx_valid", tx_valid, 0);
    bus_rd(32'h08, 1, "R1 busy");
    bus_rd(32'h0C, 0, "R1 rx count");
    bus_rd(32'h10, 0, "R1 tx count");
    bus_rd(32'h14, 0, "R1 flags");
    // R2 map and aliasing
    bus_rd(32'hFFFF_FF00, ID0, "R2 id0 alias");
    bus_rd(32'h44, ID1, "R2 id1 alias");
    bus_rd(32'h18, 0, "R2 info zero");
    bus_rd(32'h20, 0, "R2 tx data reads zero");
    bus_rd(32'h3C, 0, "R2 unmapped");
    // R10 zero write releases busy
    bus_wr(32'h14, 0);
    bus_rd(32'h08, 0, "R10 busy after zero write");
    @(negedge clk); chk("R3 ready when idle", rx_ready, 1);
    // R4 accept 5-byte frame
    send_rx(5, 8'h10);
    bus_rd(32'h0C, 5, "R4 rx count");
    bus_rd(32'h14, 2, "R4 receive done");
    bus_rd(32'h08, 1, "R4 busy");
    // R6 sequential reads
    bus_rd(32'h1C, 8'h10, "R6 first byte");
    bus_rd(32'h1C, 8'h11, "R6 second byte");
    bus_rd(32'h0C, 3, "R6 count after reads");
    // R3 stall while busy
    @(posedge clk); #1 rx_valid = 1; rx_data = 8'h77; rx_last = 1;
    repeat (4) @(posedge clk);
    @(negedge clk); chk("R3 not ready while busy", rx_ready, 0);
    @(posedge clk); #1 rx_valid = 0; rx_last = 0;
    bus_rd(32'h0C, 3, "R3 count unchanged under stall");
    // R10 priority: bit0 wins over bit1
    bus_wr(32'h14, 32'h3);
    bus_rd(32'h14, 2, "R10 bit0 priority keeps rx flag");
    bus_wr(32'h14, 32'h2);
    bus_rd(32'h14, 0, "R10 rx flag cleared");
    bus_rd(32'h08, 0, "R10 busy follows flags");
    // R5 oversized frame dropped
    send_rx(ML, 8'h40);
    bus_rd(32'h0C, 3, "R5 count kept after drop");
    bus_rd(32'h14, 0, "R5 flags kept after drop");
    // R4 largest legal frame
    send_rx(ML - 1, 8'h80);
    bus_rd(32'h0C, ML - 1, "R4 max legal frame");
    for (int i = 0; i < ML - 1; i++) bus_rd(32'h1C, 8'h80 + i, "R6 drain byte");
    bus_rd(32'h1C, 0, "R6 read at zero count");
    bus_rd(32'h0C, 0, "R6 count stays zero");
    bus_wr(32'h14, 32'h2);
    // small rx frame to hold the receive flag
    send_rx(2, 8'hC0);
    // R7 count clipping
    bus_wr(32'h10, ML + 4);
    bus_rd(32'h10, 0, "R7 oversized count");
    bus_wr(32'h10, 4);
    bus_rd(32'h10, 4, "R7 legal count");
    // R8 transmit
    got.delete();
    bus_wr(32'h20, 32'hABCD_EFA1);
    bus_wr(32'h20, 32'hABCD_EFA2);
    bus_wr(32'h20, 32'hABCD_EFA3);
    bus_rd(32'h10, 4, "R8 count held mid frame");
    bus_wr(32'h20, 32'hABCD_EFA4);
    @(negedge clk); chk("R8 frame out", tx_valid, 1); chk("R8 first byte", tx_data, 8'hA1);
    bus_wr(32'h20, 32'h55);   // R9 ignored
    bus_rd(32'h14, 3, "R8 transmit done");
    bus_rd(32'h10, 0, "R8 count zeroed");
    @(posedge clk); #1 tx_ready = 1;
    drain();
    chk("R8 byte count", got.size(), 4);
    for (int i = 0; i < 4 && i < got.size(); i++) chk("R8 byte order", got[i], 8'hA1 + i);
    bus_wr(32'h14, 32'h8000_0003);
    bus_rd(32'h14, 2, "R10 bit0 over bit31");
    bus_wr(32'h14, 32'h8000_0002);
    bus_rd(32'h14, 0, "R10 bit1 over bit31");
    // R9/R8 limit send with no count
    got.delete();
    for (int i = 0; i < ML - 1; i++) bus_wr(32'h20, i);
    @(negedge clk); chk("R9 ignored write not counted", tx_valid, 0);
    bus_wr(32'h20, ML - 1);
    drain();
    chk("R8 limit frame length", got.size(), ML);
    if (got.size() > 0) chk("R9 first byte intact", got[0], 0);
    bus_wr(32'h14, 32'h1);
    // R10/R11 self test
    bus_wr(32'h10, 5);
    bus_wr(32'h14, 32'h8000_0000);
    bus_rd(32'h10, 0, "R10 self test resets count");
    bus_rd(32'h08, 1, "R10 busy after self test");
    bus_rd(32'h14, 32'h8000_0000, "R11 read shows test flag");
    bus_rd(32'h14, 0, "R11 test flag cleared by read");
    @(negedge clk); chk("R11 irq low", irq, 0);
    bus_wr(32'h14, 0);
    bus_rd(32'h08, 0, "R10 zero write clears busy");
    repeat (3) @(posedge clk);
    finish_run();
  end
endmodule